// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Run-Time Frame Formats

This block turns bytes written by a host into asynchronous serial frames on a single output line. A one-cycle write strobe places a byte in a holding register. On the next bit boundary the byte moves into a shift stage, and the holding register becomes free for the next byte. The shift stage then sends a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits. While the shift stage is busy the host may already load the following byte, so consecutive frames leave the line with no idle gap between them.

A 3-bit format code selects the frame layout when each byte enters the shift stage. Seven- and eight-bit data, even, odd or no parity, and one or two stop bits are available. Bit timing comes from an external transmit bit clock. The block synchronises that clock into its own clock domain and divides its rising edges by 1, 16 or 64, as set by a 2-bit divide code. A break input holds the line low for as long as it is asserted. Frame timing carries on unchanged underneath the break.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is high (idle) and `tx_empty` is high. An asynchronous reset taken in the middle of a frame returns `txd` high and `tx_empty` high at once, and no part of that frame is sent afterwards.
- R2: A frame consists of one low start bit, then the data bits least significant bit first, then the parity bit when the format has one, then the stop bits, which are high. When no frame is active the line is high.
- R3: Format code mapping (data bits / parity / stop bits): 000 = 7/even/2, 001 = 7/odd/2, 010 = 7/even/1, 011 = 7/odd/1, 100 = 8/none/2, 101 = 8/none/1, 110 = 8/even/1, 111 = 8/odd/1. The code is captured when a byte enters the shift stage.
- R4: The parity bit is computed over the selected data bits only. With even parity, those bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R5: In the 7-bit formats, bit 7 of the written byte does not appear on the line and does not affect parity.
- R6: Every bit lasts N rising edges of `bit_clk`, with N = 1 for divide code 00, 16 for 01, and 64 for 10 and 11. A frame begins only on a bit boundary.
- R7: A one-cycle `wr_stb` loads `wr_data` into the holding register. `tx_empty` is low in the cycle after the strobe.
- R8: `tx_empty` rises in the cycle in which the held byte moves into the shift stage. A byte written while the previous frame is still being sent follows that frame's last stop bit with no idle gap.
- R9: `txd` is low from the cycle after `brk_req` is asserted for as long as it stays asserted. Frame timing continues underneath, and once the break is released the line shows the current bit of the frame again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle load strobe for the holding register |
| wr_data | input | 8 | Byte to be sent |
| fmt_code | input | 3 | Frame format code (see R3) |
| div_code | input | 2 | Bit clock divide code (see R6) |
| bit_clk | input | 1 | External transmit bit clock, asynchronous to `clk` |
| brk_req | input | 1 | Break request: forces the line low |
| txd | output | 1 | Serial data line |
| tx_empty | output | 1 | High when the holding register can take a new byte |

## Verification
The status and break results are due exactly one cycle after their stimulus. `tx_empty` falls in the cycle after a strobe, and `txd` falls in the cycle after `brk_req` is raised. The bench samples both at the next falling clock edge. Frame bits have no fixed latency from the write, because a frame waits for the next bit boundary and the `bit_clk` edges pass through a synchroniser. The bench therefore waits for the falling start edge, moves half a bit period forward and then samples once per bit period, so every sample lands mid-bit whatever the phase. For back-to-back frames, the wait for the second start edge must not exceed half a bit period plus the sampling slack.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int SER_DATA_W   = 8;
    localparam int SER_DIV_MID  = 16;
    localparam int SER_DIV_SLOW = 64;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_e;

    typedef struct packed {
        logic wide;      // 1: full byte, 0: byte minus top bit
        par_e par;
        logic two_stop;
    } fmt_t;

    function automatic fmt_t decode_fmt(input logic [2:0] code);
        fmt_t f;
        f.wide     = code[2];
        f.two_stop = (code == 3'b000) || (code == 3'b001) || (code == 3'b100);
        case (code)
            3'b100, 3'b101:         f.par = PAR_NONE;
            3'b000, 3'b010, 3'b110: f.par = PAR_EVEN;
            default:                f.par = PAR_ODD;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MID     = 16,
    parameter int DIV_SLOW    = 64,
    localparam int DIV_W      = $clog2(DIV_SLOW)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk,
    input  logic [1:0] div_code,
    output logic       tick
);

    typedef struct packed {
        logic [SYNC_STAGES:0] sync;
        logic [DIV_W-1:0]     cnt;
        logic                 tick;
    } tk_t;

    localparam logic [DIV_W-1:0] LIM_ONE  = '0;
    localparam logic [DIV_W-1:0] LIM_MID  = DIV_W'(DIV_MID - 1);
    localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(DIV_SLOW - 1);

    tk_t              tk_d, tk_q;
    logic             rise;
    logic [DIV_W-1:0] lim;

    always_comb begin
        tk_d      = tk_q;
        tk_d.sync = {tk_q.sync[SYNC_STAGES-1:0], bit_clk};
        rise      = tk_q.sync[SYNC_STAGES-1] & ~tk_q.sync[SYNC_STAGES];
        case (div_code)
            2'b00:   lim = LIM_ONE;
            2'b01:   lim = LIM_MID;
            default: lim = LIM_SLOW;
        endcase
        tk_d.tick = 1'b0;
        if (rise) begin
            if (tk_q.cnt >= lim) begin
                tk_d.cnt  = '0;
                tk_d.tick = 1'b1;
            end else begin
                tk_d.cnt = tk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick = tk_q.tick;

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hd_t;

    hd_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (take) hd_d.full = 1'b0;
        if (wr_stb) begin
            hd_d.data = wr_data;
            hd_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign hold_data = hd_q.data;
    assign full      = hd_q.full;

    AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> hd_q.full) else $error("holding register not full after write"); // R7

    AST_EMPTY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hd_q.full) |-> $past(take)) else $error("holding register emptied without transfer"); // R8

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift import sertx_pkg::*; #(
    parameter int DATA_W   = 8,
    localparam int FRAME_W = DATA_W + 3,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [2:0]        fmt_code,
    output logic              take,
    output logic              line
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
    } sh_t;

    sh_t                sh_d, sh_q;
    fmt_t               fmt;
    logic [FRAME_W-1:0] fr_new;
    logic               ones;
    int                 nd_i;
    int                 len_i;

    // Frame image for the held byte, bit 0 goes out first.
    always_comb begin
        fmt    = decode_fmt(fmt_code);
        nd_i   = fmt.wide ? DATA_W : DATA_W - 1;
        fr_new = '1;
        fr_new[0] = 1'b0;
        ones   = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd_i) begin
                fr_new[1 + i] = hold_data[i];
                ones          = ones ^ hold_data[i];
            end
        end
        if (fmt.par != PAR_NONE) begin
            fr_new[1 + nd_i] = (fmt.par == PAR_ODD) ? ~ones : ones;
        end
        len_i = 1 + nd_i + ((fmt.par != PAR_NONE) ? 1 : 0) + (fmt.two_stop ? 2 : 1);
    end

    always_comb begin
        sh_d = sh_q;
        take = 1'b0;
        if (tick) begin
            if (sh_q.left > CNT_W'(1)) begin
                sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
                sh_d.left  = sh_q.left - 1'b1;
            end else if (full) begin
                sh_d.frame = fr_new;
                sh_d.left  = CNT_W'(len_i);
                take       = 1'b1;
            end else begin
                sh_d.frame = '1;
                sh_d.left  = '0;
            end
        end
        line = (sh_q.left != '0) ? sh_q.frame[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{frame: '1, left: '0};
        else        sh_q <= sh_d;
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line == 1'b0)) else $error("frame did not open with a low start bit"); // R2

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sh_q.left)) else $error("bit position moved without a bit tick"); // R6

endmodule

// File: rtl/sertx_top.sv
module sertx_top import sertx_pkg::*; #(
    parameter int DATA_W      = SER_DATA_W,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MID     = SER_DIV_MID,
    parameter int DIV_SLOW    = SER_DIV_SLOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        fmt_code,
    input  logic [1:0]        div_code,
    input  logic              bit_clk,
    input  logic              brk_req,
    output logic              txd,
    output logic              tx_empty
);

    logic              tick;
    logic              take;
    logic              full;
    logic              line;
    logic [DATA_W-1:0] hold_data;
    logic              txd_d, txd_q;

    sertx_tick #(
        .SYNC_STAGES (SYNC_STAGES),
        .DIV_MID     (DIV_MID),
        .DIV_SLOW    (DIV_SLOW)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_clk  (bit_clk),
        .div_code (div_code),
        .tick     (tick)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .full      (full)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .full      (full),
        .hold_data (hold_data),
        .fmt_code  (fmt_code),
        .take      (take),
        .line      (line)
    );

    always_comb begin
        txd_d = brk_req ? 1'b0 : line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_d;
    end

    assign txd      = txd_q;
    assign tx_empty = ~full;

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !txd) else $error("line not low during break"); // R9

endmodule

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] fmt_code = 3'b101;
    logic [1:0] div_code = 2'b00;
    logic       bit_clk = 1'b0;
    logic       brk_req = 1'b0;
    logic       txd;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int CLK_PER_BCLK = 4;

    // {fmt_code, div_code, data}
    localparam logic [12:0] VEC [8] = '{
        {3'b000, 2'b00, 8'h35},
        {3'b001, 2'b01, 8'hC3},
        {3'b010, 2'b00, 8'hFF},
        {3'b011, 2'b00, 8'h80},
        {3'b100, 2'b00, 8'h5A},
        {3'b101, 2'b10, 8'h01},
        {3'b110, 2'b01, 8'h7E},
        {3'b111, 2'b11, 8'h96}
    };

    sertx_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .fmt_code (fmt_code),
        .div_code (div_code),
        .bit_clk  (bit_clk),
        .brk_req  (brk_req),
        .txd      (txd),
        .tx_empty (tx_empty)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (CLK_PER_BCLK / 2) @(posedge clk);
            bit_clk <= ~bit_clk;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ratio(input logic [1:0] dc);
        return (dc == 2'b00) ? 1 : (dc == 2'b01) ? 16 : 64;
    endfunction

    // Expected frame from the format table, bit 0 first.
    function automatic void exp_frame(input logic [2:0] f, input logic [7:0] d,
                                      output logic [11:0] b, output int n);
        int nd; int pm; int ns; int ones;
        case (f)
            3'b000: begin nd = 7; pm = 1; ns = 2; end
            3'b001: begin nd = 7; pm = 2; ns = 2; end
            3'b010: begin nd = 7; pm = 1; ns = 1; end
            3'b011: begin nd = 7; pm = 2; ns = 1; end
            3'b100: begin nd = 8; pm = 0; ns = 2; end
            3'b101: begin nd = 8; pm = 0; ns = 1; end
            3'b110: begin nd = 8; pm = 1; ns = 1; end
            default: begin nd = 8; pm = 2; ns = 1; end
        endcase
        b = '1; n = 0; ones = 0;
        b[n] = 1'b0; n++;
        for (int i = 0; i < nd; i++) begin
            b[n] = d[i]; ones += int'(d[i]); n++;
        end
        if (pm != 0) begin
            b[n] = (pm == 1) ? ((ones % 2) == 1) : ((ones % 2) == 0);
            n++;
        end
        n += ns;
    endfunction

    task automatic rx_frame(input int n, input int per, output logic [11:0] bits, output int waited);
        bits = '1; waited = 0;
        while (txd !== 1'b0 && waited < 20000) begin
            @(negedge clk); waited++;
        end
        repeat (per / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (per) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] got, expv, got2, expv2;
        int n, n2, w, w2, lows;

        repeat (5) @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", 32'(txd), 1);
        chk(tx_empty === 1'b1, "R1 reset empty", 32'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R1 idle after reset", {30'd0, txd, tx_empty}, 3);

        // Table walk: every format code and every divide code.
        for (int v = 0; v < 8; v++) begin
            fmt_code = VEC[v][12:10];
            div_code = VEC[v][9:8];
            exp_frame(VEC[v][12:10], VEC[v][7:0], expv, n);
            write_byte(VEC[v][7:0]);
            rx_frame(n, ratio(VEC[v][9:8]) * CLK_PER_BCLK, got, w);
            chk(got === expv, $sformatf("R2 R3 R4 R5 R6 vector %0d", v), 32'(got), 32'(expv));
        end
        repeat (400) @(negedge clk);

        // Double buffering: second byte written while the first is on the line.
        fmt_code = 3'b101; div_code = 2'b00;
        exp_frame(3'b101, 8'h3C, expv, n);
        exp_frame(3'b101, 8'hA9, expv2, n2);
        fork
            begin
                rx_frame(n, CLK_PER_BCLK, got, w);
                rx_frame(n2, CLK_PER_BCLK, got2, w2);
            end
            begin
                write_byte(8'h3C);
                chk(tx_empty === 1'b0, "R7 empty low after strobe", 32'(tx_empty), 0);
                while (!tx_empty) @(negedge clk);
                write_byte(8'hA9);
                chk(tx_empty === 1'b0, "R8 second byte held during first frame", 32'(tx_empty), 0);
            end
        join
        chk(got === expv, "R8 first frame", 32'(got), 32'(expv));
        chk(got2 === expv2, "R8 second frame", 32'(got2), 32'(expv2));
        chk(w2 <= CLK_PER_BCLK / 2 + 1, "R8 no idle gap", 32'(w2), CLK_PER_BCLK / 2 + 1);
        repeat (20) @(negedge clk);
        chk(tx_empty === 1'b1 && txd === 1'b1, "R2 idle after frames", {30'd0, txd, tx_empty}, 3);

        // Break during a frame of all-ones data.
        div_code = 2'b01;
        write_byte(8'hFF);
        w = 0;
        while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        repeat (80) @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R9 break low next cycle", 32'(txd), 0);
        repeat (29) @(negedge clk);
        chk(txd === 1'b0, "R9 break still low", 32'(txd), 0);
        brk_req = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 data bit shown after break", 32'(txd), 1);
        repeat (1000) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R9 frame finished after break", {30'd0, txd, tx_empty}, 3);

        // Break while idle.
        brk_req = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R9 idle break low", 32'(txd), 0);
        brk_req = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 idle after break release", 32'(txd), 1);

        // Reset in the middle of a frame.
        write_byte(8'h00);
        w = 0;
        while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        repeat (20) @(negedge clk);
        write_byte(8'h55);
        rst_n = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R1 reset mid-frame txd", 32'(txd), 1);
        chk(tx_empty === 1'b1, "R1 reset mid-frame empty", 32'(tx_empty), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, "R1 nothing sent after reset", 32'(lows), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule